// File: doc/BRIEF.md
# Programmable Address Region Decoder

This block classifies every bus cycle by address. It holds a bank of programmable regions. Each region has a base address, a power-of-two size, a memory or I/O selector, a destination code, a chip select number and two protection flags. For every cycle, the address is compared against all enabled regions at once. The matching region with the lowest index decides three things:
- where the cycle goes: main memory, the peripheral bus or nowhere;
- which chip select line is asserted;
- whether the access is restricted.

Restrictions work in two ways. A write into a write-protected region is flagged as blocked, whichever master issues it. The first such violation latches a sticky interrupt together with the offending region and master. A code fetch by the CPU from a no-execute region gets a fixed illegal-opcode pattern in place of the memory data, so the CPU traps. Several separate regions may name one chip select. A pin-enable mask decides which chip selects actually reach their pins, so a decoded chip select can also be left internal for a peripheral that decodes addresses itself.

The decode path is combinational from the cycle inputs to the outputs. Configuration writes land on the next clock edge.

Top module: `ard_top`

## Requirements
- R1: After synchronous reset, all regions are disabled, the pin-enable mask is zero and the interrupt is low. With no region matching, a memory cycle decodes to main memory (target code 1) and an I/O cycle decodes to target code 0. In both cases no chip select is asserted, no write is blocked and read data passes through unchanged.
- R2: A region matches when three conditions hold: its enable bit (control bit 0) is 1, its I/O bit (control bit 1) equals the cycle's I/O flag, and the cycle address agrees with the base in every bit from position `size` (control bits 13:9) upward. Base bits below that position are ignored.
- R3: When several enabled regions match, the lowest-numbered one alone determines every output.
- R4: The target output equals the winning region's target field (control bits 3:2; 1 = main memory, 2 = peripheral bus). The chip select vector is one-hot at the region's chip select number (control bits 6:4) only when that target is 2. Otherwise it is zero.
- R5: Two or more regions with disjoint ranges that name the same chip select number each assert that same chip select line when they match.
- R6: The pin output equals the chip select vector ANDed with the pin-enable mask (configuration address 2N, low bits).
- R7: A write cycle that hits a region with write-protect set (control bit 7) raises the blocked flag, for CPU (code 0), PCI (code 1) and DMA (code 2) masters alike. Reads and fetches from that region are never blocked.
- R8: A CPU read with the fetch flag set, on a memory cycle that hits a region with no-execute set (control bit 8), returns the pattern 0x0F in the low byte and 0x0B in the next byte, repeated across the data width, and raises the substitute flag. The same access by any other master, or as a data read, returns the input data.
- R9: The first blocked write on a valid cycle sets the sticky interrupt and latches the region index and master code. Later violations leave the latched values alone. Writing 1 to bit 0 of configuration address 2N+1 clears the interrupt. If a violation arrives in the same cycle as a clear, the violation wins and is latched.
- R10: A configuration write (base at address i, control at address N+i) has no effect on the decode of the cycle in which it is presented. It applies from the next clock edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| cyc_valid | input | 1 | Bus cycle is valid this clock |
| cyc_addr | input | 32 | Cycle address |
| cyc_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| cyc_wr | input | 1 | 1 = write |
| cyc_fetch | input | 1 | Read is a code fetch |
| cyc_master | input | 2 | Requesting master: 0 CPU, 1 PCI, 2 DMA |
| rd_data_in | input | 32 | Data returned by the addressed target |
| tgt | output | 2 | Decoded destination |
| cs_sel | output | 8 | One-hot decoded chip select |
| cs_pin | output | 8 | Chip selects driven to pins |
| wr_block | output | 1 | Write suppressed by protection |
| op_sub | output | 1 | Fetch data replaced by illegal opcode |
| rd_data_out | output | 32 | Data delivered to the requester |
| viol_irq | output | 1 | Sticky violation interrupt |
| viol_region | output | 4 | Region of the latched violation |
| viol_master | output | 2 | Master of the latched violation |

## Verification
The properties assume that the master code never takes the unused value 3. They also assume that a clear write is the only way the interrupt may fall, and that the fetch flag comes only with reads. The stimulus keeps to these limits. Masters are drawn from 0 to 2, the fetch flag is forced low whenever the write flag is high, and clears are issued only through the configuration port. Cycle addresses are mostly drawn near the programmed bases, so that overlapping, shared and disabled regions are all hit.

// File: rtl/ard_pkg.sv
package ard_pkg;
  localparam int CSN_W  = 3;
  localparam int SIZE_W = 5;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_SDRAM = 2'd1,
    TGT_PBUS  = 2'd2,
    TGT_RSVD  = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    MST_CPU = 2'd0,
    MST_PCI = 2'd1,
    MST_DMA = 2'd2,
    MST_UNU = 2'd3
  } mst_e;

  // control word, bit 0 upward: en, io, tgt[1:0], csn[2:0], wp, nx, size[4:0]
  typedef struct packed {
    logic [SIZE_W-1:0] size;
    logic              nx;
    logic              wp;
    logic [CSN_W-1:0]  csn;
    logic [1:0]        tgt;
    logic              io;
    logic              en;
  } rgn_ctrl_t;

  localparam int CTRL_W = $bits(rgn_ctrl_t);
endpackage

// File: rtl/ard_region_bank.sv
module ard_region_bank import ard_pkg::*; #(
  parameter int N_REG  = 16,
  parameter int ADDR_W = 32,
  parameter int N_CS   = 8,
  parameter int CFG_AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic              cyc_io,
  output logic [N_REG-1:0]  hit_vec,
  output rgn_ctrl_t         ctrl_q [N_REG],
  output logic [N_CS-1:0]   pin_en_q,
  output logic              clr_pulse
);
  localparam int PIN_ADDR = 2 * N_REG;
  localparam int CLR_ADDR = 2 * N_REG + 1;

  logic [ADDR_W-1:0] base_q [N_REG];

  assign clr_pulse = cfg_we && (int'(cfg_addr) == CLR_ADDR) && cfg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_en_q <= '0;
    end else if (cfg_we && int'(cfg_addr) == PIN_ADDR) begin
      pin_en_q <= cfg_wdata[N_CS-1:0];
    end
  end

  for (genvar g = 0; g < N_REG; g++) begin : g_rgn
    logic [ADDR_W-1:0] keep_mask;

    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[g] <= '0;
        ctrl_q[g] <= '0;
      end else if (cfg_we) begin
        if (int'(cfg_addr) == g)
          base_q[g] <= cfg_wdata;
        if (int'(cfg_addr) == N_REG + g)
          ctrl_q[g] <= rgn_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
      end
    end

    assign keep_mask  = {ADDR_W{1'b1}} << ctrl_q[g].size;
    assign hit_vec[g] = ctrl_q[g].en && (ctrl_q[g].io == cyc_io) &&
                        (((cyc_addr ^ base_q[g]) & keep_mask) == '0);
  end
endmodule

// File: rtl/ard_prio_pick.sv
module ard_prio_pick #(
  parameter int N_REG = 16,
  parameter int IDX_W = $clog2(N_REG)
) (
  input  logic [N_REG-1:0] hit_vec,
  output logic             any_hit,
  output logic [IDX_W-1:0] win_idx
);
  always_comb begin
    win_idx = '0;
    for (int i = N_REG - 1; i >= 0; i--) begin
      if (hit_vec[i]) win_idx = IDX_W'(i);
    end
  end
  assign any_hit = |hit_vec;
endmodule

// File: rtl/ard_viol_track.sv
module ard_viol_track #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_i,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [1:0]       set_mst,
  input  logic             clr_i,
  output logic             irq_q,
  output logic [IDX_W-1:0] idx_q,
  output logic [1:0]       mst_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      idx_q <= '0;
      mst_q <= '0;
    end else if (set_i && (!irq_q || clr_i)) begin
      irq_q <= 1'b1;
      idx_q <= set_idx;
      mst_q <= set_mst;
    end else if (clr_i) begin
      irq_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ard_top.sv
module ard_top import ard_pkg::*; #(
  parameter int N_REG  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int N_CS   = 8,
  parameter int IDX_W  = $clog2(N_REG),
  parameter int CFG_AW = $clog2(N_REG) + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              cyc_valid,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic              cyc_io,
  input  logic              cyc_wr,
  input  logic              cyc_fetch,
  input  logic [1:0]        cyc_master,
  input  logic [DATA_W-1:0] rd_data_in,
  output logic [1:0]        tgt,
  output logic [N_CS-1:0]   cs_sel,
  output logic [N_CS-1:0]   cs_pin,
  output logic              wr_block,
  output logic              op_sub,
  output logic [DATA_W-1:0] rd_data_out,
  output logic              viol_irq,
  output logic [IDX_W-1:0]  viol_region,
  output logic [1:0]        viol_master
);
  localparam int LANES = DATA_W / 16;

  logic [N_REG-1:0]  hit_vec;
  rgn_ctrl_t         ctrl_q [N_REG];
  logic [N_CS-1:0]   pin_en_q;
  logic              clr_pulse;
  logic              any_hit;
  logic [IDX_W-1:0]  win_idx;
  rgn_ctrl_t         win;
  logic [DATA_W-1:0] bad_op;

  ard_region_bank #(.N_REG(N_REG), .ADDR_W(ADDR_W), .N_CS(N_CS), .CFG_AW(CFG_AW)) u_bank (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cyc_addr(cyc_addr), .cyc_io(cyc_io), .hit_vec(hit_vec), .ctrl_q(ctrl_q),
    .pin_en_q(pin_en_q), .clr_pulse(clr_pulse)
  );

  ard_prio_pick #(.N_REG(N_REG), .IDX_W(IDX_W)) u_pick (
    .hit_vec(hit_vec), .any_hit(any_hit), .win_idx(win_idx)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign bad_op[16*l +: 16] = 16'h0B0F;
  end

  assign win = ctrl_q[win_idx];

  always_comb begin
    if (any_hit)     tgt = win.tgt;
    else if (cyc_io) tgt = TGT_NONE;
    else             tgt = TGT_SDRAM;
  end

  always_comb begin
    cs_sel = '0;
    if (any_hit && win.tgt == TGT_PBUS) cs_sel[win.csn] = 1'b1;
  end

  assign cs_pin      = cs_sel & pin_en_q;
  assign wr_block    = any_hit && win.wp && cyc_wr;
  assign op_sub      = any_hit && win.nx && cyc_fetch && !cyc_wr && !cyc_io &&
                       (cyc_master == MST_CPU);
  assign rd_data_out = op_sub ? bad_op : rd_data_in;

  ard_viol_track #(.IDX_W(IDX_W)) u_viol (
    .clk(clk), .rst(rst), .set_i(cyc_valid && wr_block), .set_idx(win_idx),
    .set_mst(cyc_master), .clr_i(clr_pulse), .irq_q(viol_irq), .idx_q(viol_region),
    .mst_q(viol_master)
  );
endmodule

// File: rtl/ard_checker.sv
module ard_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int N_CS   = 8,
  parameter int IDX_W  = 4,
  parameter int CFG_AW = 6,
  parameter int N_REG  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [ADDR_W-1:0] cfg_wdata,
  input logic              cyc_valid,
  input logic              cyc_wr,
  input logic              cyc_fetch,
  input logic [1:0]        cyc_master,
  input logic [DATA_W-1:0] rd_data_in,
  input logic [N_CS-1:0]   cs_sel,
  input logic [N_CS-1:0]   cs_pin,
  input logic              wr_block,
  input logic              op_sub,
  input logic [DATA_W-1:0] rd_data_out,
  input logic              viol_irq,
  input logic [IDX_W-1:0]  viol_region
);
  logic clr_wr;
  assign clr_wr = cfg_we && (int'(cfg_addr) == 2 * N_REG + 1) && cfg_wdata[0];

  AST_CS_ONEHOT:   assert property (@(posedge clk) disable iff (rst) $onehot0(cs_sel)); // R4
  AST_PIN_SUBSET:  assert property (@(posedge clk) disable iff (rst) (cs_pin & ~cs_sel) == '0); // R6
  AST_BLOCK_WRITE: assert property (@(posedge clk) disable iff (rst) wr_block |-> cyc_wr); // R7
  AST_SUB_CPU:     assert property (@(posedge clk) disable iff (rst) op_sub |-> (cyc_fetch && cyc_master == 2'd0)); // R8
  AST_PASS_DATA:   assert property (@(posedge clk) disable iff (rst) !op_sub |-> rd_data_out == rd_data_in); // R8
  AST_IRQ_SET:     assert property (@(posedge clk) disable iff (rst) (cyc_valid && wr_block) |=> viol_irq); // R9
  AST_IRQ_HOLD:    assert property (@(posedge clk) disable iff (rst) (viol_irq && !clr_wr) |=> (viol_irq && $stable(viol_region))); // R9
  AST_IRQ_CLEAR:   assert property (@(posedge clk) disable iff (rst) (clr_wr && !(cyc_valid && wr_block)) |=> !viol_irq); // R9
endmodule

bind ard_top ard_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_CS(N_CS), .IDX_W(IDX_W), .CFG_AW(CFG_AW), .N_REG(N_REG)
) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .cyc_valid(cyc_valid), .cyc_wr(cyc_wr), .cyc_fetch(cyc_fetch), .cyc_master(cyc_master),
  .rd_data_in(rd_data_in), .cs_sel(cs_sel), .cs_pin(cs_pin), .wr_block(wr_block),
  .op_sub(op_sub), .rd_data_out(rd_data_out), .viol_irq(viol_irq), .viol_region(viol_region)
);

// File: tb/tb_ard_top.sv
module tb_ard_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [5:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic cyc_valid = 1'b0;
  logic [31:0] cyc_addr = '0;
  logic cyc_io = 1'b0, cyc_wr = 1'b0, cyc_fetch = 1'b0;
  logic [1:0] cyc_master = '0;
  logic [31:0] rd_data_in = '0;
  logic [1:0] tgt;
  logic [7:0] cs_sel, cs_pin;
  logic wr_block, op_sub, viol_irq;
  logic [31:0] rd_data_out;
  logic [3:0] viol_region;
  logic [1:0] viol_master;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ard_top dut (.*);

  // reference state
  logic [31:0] m_base [16];
  logic [31:0] m_ctrl [16];
  logic [7:0]  m_pin;
  bit          m_irq;
  int          m_vreg, m_vmst;
  bit          e_blk;
  int          e_win;

  task automatic chk(string req, string what, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int find_win(logic [31:0] a, logic io);
    for (int i = 0; i < 16; i++) begin
      logic [31:0] msk;
      msk = 32'hFFFF_FFFF << m_ctrl[i][13:9];
      if (m_ctrl[i][0] && m_ctrl[i][1] == io && ((a ^ m_base[i]) & msk) == 0) return i;
    end
    return -1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin m_base[i] = 0; m_ctrl[i] = 0; end
    m_pin = 0; m_irq = 0; m_vreg = 0; m_vmst = 0;
  endtask

  task automatic compare(string tag);
    int w; int et; logic [7:0] ecs; bit esub; logic [31:0] erd;
    w = find_win(cyc_addr, cyc_io);
    e_win = w;
    if (w < 0) et = cyc_io ? 0 : 1; else et = int'(m_ctrl[w][3:2]);
    ecs = 0;
    if (w >= 0 && m_ctrl[w][3:2] == 2) ecs[m_ctrl[w][6:4]] = 1'b1;
    e_blk = (w >= 0) && m_ctrl[w][7] && cyc_wr;
    esub = (w >= 0) && m_ctrl[w][8] && cyc_fetch && !cyc_wr && !cyc_io && cyc_master == 0;
    erd = esub ? 32'h0B0F_0B0F : rd_data_in;
    chk(tag, "tgt", tgt, et);
    chk(tag, "cs_sel", cs_sel, ecs);
    chk("R6", "cs_pin", cs_pin, ecs & m_pin);
    chk("R7", "wr_block", wr_block, e_blk);
    chk("R8", "op_sub", op_sub, esub);
    chk("R8", "rd_data_out", rd_data_out, erd);
    chk("R9", "viol_irq", viol_irq, m_irq);
    if (m_irq) begin
      chk("R9", "viol_region", viol_region, m_vreg);
      chk("R9", "viol_master", viol_master, m_vmst);
    end
  endtask

  task automatic model_edge();
    bit clr;
    clr = cfg_we && cfg_addr == 33 && cfg_wdata[0];
    if (cyc_valid && e_blk && (!m_irq || clr)) begin
      m_irq = 1; m_vreg = e_win; m_vmst = cyc_master;
    end else if (clr) m_irq = 0;
    if (cfg_we) begin
      if (cfg_addr < 16) m_base[cfg_addr] = cfg_wdata;
      else if (cfg_addr < 32) m_ctrl[cfg_addr-16] = cfg_wdata & 32'h3FFF;
      else if (cfg_addr == 32) m_pin = cfg_wdata[7:0];
    end
  endtask

  // one clock: drive at falling edge, compare, then let the rising edge act
  task automatic step(string tag, bit we, int ca, logic [31:0] cd, bit v, logic [31:0] a,
                      bit io, bit wr, bit f, int m);
    @(negedge clk);
    cfg_we = we; cfg_addr = 6'(ca); cfg_wdata = cd;
    cyc_valid = v; cyc_addr = a; cyc_io = io; cyc_wr = wr; cyc_fetch = f && !wr;
    cyc_master = 2'(m); rd_data_in = $urandom;
    #1 compare(tag);
    @(posedge clk);
    #0.1 model_edge();
  endtask

  task automatic cfg(int ca, logic [31:0] d);
    step("R10", 1, ca, d, 0, 32'h0, 0, 0, 0, 0);
  endtask

  function automatic logic [31:0] ctl(bit en, bit io, int t, int cs, bit wp, bit nx, int sz);
    return {18'b0, 5'(sz), nx, wp, 3'(cs), 2'(t), io, en};
  endfunction

  logic [31:0] pick_addr [8] = '{32'h1234, 32'h0, 32'h3F8, 32'h2F8, 32'h8000_0000,
                                 32'h100, 32'h2000, 32'h4_0000};

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: reset state, nothing programmed
    #1;
    chk("R1", "viol_irq", viol_irq, 0);
    chk("R1", "tgt mem", tgt, 1);
    for (int i = 0; i < 6; i++)
      step("R1", 0, 0, 0, 1, $urandom, i[0], i[1], 1, i % 3);
    // R10: write control of region 0 while a cycle hits its future range
    m_base[0] = 0;
    step("R10", 1, 16, ctl(1, 0, 2, 3, 1, 0, 12), 1, 32'h0000_0100, 0, 1, 0, 0);
    step("R10", 0, 0, 0, 1, 32'h0000_0100, 0, 1, 0, 0);
    cfg(33, 1);
    // program the map
    cfg(0, 32'h0000_1234);  cfg(16, ctl(1, 0, 1, 0, 1, 0, 12)); // R2 low base bits ignored
    cfg(1, 32'h0000_0000);  cfg(17, ctl(1, 0, 1, 0, 0, 1, 16)); // overlaps region 0 (R3)
    cfg(2, 32'h0000_03F8);  cfg(18, ctl(1, 1, 2, 5, 0, 0, 3));  // R5
    cfg(3, 32'h0000_02F8);  cfg(19, ctl(1, 1, 2, 5, 0, 0, 3));  // R5 shares cs 5
    cfg(4, 32'h8000_0000);  cfg(20, ctl(1, 0, 2, 2, 1, 1, 20));
    cfg(5, 32'h0000_0100);  cfg(21, ctl(1, 1, 2, 7, 1, 0, 4));
    cfg(6, 32'h0000_2000);  cfg(22, ctl(0, 0, 2, 1, 1, 1, 8));  // disabled
    cfg(32, 32'h0000_0020);                                     // R6 only cs 5 to pin
    // R3: inside both 0 and 1, region 0 wins (write-protected, executable)
    step("R3", 0, 0, 0, 1, 32'h0000_1800, 0, 1, 0, 1);
    step("R3", 0, 0, 0, 1, 32'h0000_1800, 0, 0, 1, 0);
    step("R3", 0, 0, 0, 1, 32'h0000_3000, 0, 0, 1, 0);
    // R5: both I/O ranges on cs 5
    step("R5", 0, 0, 0, 1, 32'h0000_03FA, 1, 0, 0, 0);
    step("R5", 0, 0, 0, 1, 32'h0000_02FF, 1, 0, 0, 0);
    // R9: clear and violation in the same cycle, violation wins
    step("R9", 1, 33, 1, 1, 32'h8000_0010, 0, 1, 0, 2);
    step("R9", 0, 0, 0, 1, 32'h0000_0108, 1, 1, 0, 1);
    // random traffic around programmed ranges
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a; int k; bit we; int ca; logic [31:0] cd;
      k = $urandom_range(0, 8);
      a = (k == 8) ? $urandom : pick_addr[k] + $urandom_range(0, 40);
      we = ($urandom_range(0, 19) == 0);
      ca = 33; cd = $urandom_range(0, 1);
      if (we && $urandom_range(0, 3) == 0) begin ca = 32; cd = $urandom; end
      step((k < 6) ? "R2" : "R4", we, ca, cd, $urandom_range(0, 1), a,
           (k inside {2, 3, 5}) ? 1'b1 : 1'(($urandom_range(0, 9) == 0)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), $urandom_range(0, 2));
    end
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule